// File: doc/BRIEF.md
# Three-Phase Gate Timing Controller

This block converts per-phase enable and PWM logic levels into high-side and low-side gate commands for three MOSFET half bridges. A disabled phase keeps both of its gates off, so its output node floats. An enabled phase follows its PWM input: the high side is on while PWM is high, and the low side is on while PWM is low. Every change of side passes through a dead time in which both gates of the phase are off. All phases share one dead-time setting, counted in clock cycles.

When a phase becomes enabled, the block first holds that phase's low-side gate on for a fixed number of cycles, whatever PWM is doing. This pulse charges the bootstrap capacitor. After the pulse the phase follows PWM. A global off input from the fault supervisor clears all six gates on the next clock edge and cancels any pulse or dead-time countdown. Each gate turn-on also raises a one-cycle per-phase strobe, which the fault blanking logic uses.

Top module: `gate_timing_ctrl`

## Requirements
- R1: After reset, all gate outputs and strobes are low and the dead time equals DT_DEFAULT cycles.
- R2: While a phase enable is low, both gates of that phase are low one clock edge later and stay low whatever its PWM input does.
- R3: With the enable high and the start-up pulse finished, PWM = 1 turns on the high gate and PWM = 0 turns on the low gate.
- R4: On a clock edge where a phase enable is newly high, the phase's low gate turns on and stays on for exactly PULSE_CYCLES cycles, with the high gate off, regardless of PWM.
- R5: When the start-up pulse ends and PWM is high, the low gate turns off and both gates stay off for exactly the dead time, after which the high gate turns on. When the pulse ends and PWM is low, the low gate stays on without a gap.
- R6: When PWM changes side on an enabled phase, the conducting gate turns off at the next edge and both gates stay off for exactly the dead time before the other gate turns on.
- R7: A dt_load strobe loads max(dt_cycles, DT_MIN) as the dead time only on an edge where every phase is idle. A phase is idle when both of its gates are off and it is neither pulsing nor counting. A load on any other edge is ignored.
- R8: The high and low gates of one phase are never both high in any cycle.
- R9: all_off clears all six gates on the next edge and cancels pending pulses and countdowns. When it is released while an enable is high, that phase restarts with the start-up pulse.
- R10: sw_strobe of a phase is high for exactly the cycle in which either of that phase's gates has just turned on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| all_off | input | 1 | Global off from the fault supervisor |
| phase_en | input | NUM_PH | Per-phase enable |
| pwm_in | input | NUM_PH | Per-phase PWM level |
| dt_load | input | 1 | Request to load a new dead time |
| dt_cycles | input | DT_W | Requested dead time in cycles |
| gate_hi | output | NUM_PH | High-side gate commands |
| gate_lo | output | NUM_PH | Low-side gate commands |
| sw_strobe | output | NUM_PH | One-cycle strobe on each gate turn-on |

## Verification
Two functions can act in the same cycle. The global off can land while a start-up pulse or a dead-time countdown is pending, and it must win over both. The bench asserts all_off in the middle of a pulse and again in the middle of a dead gap. It then confirms that every gate is low on the following sample and that no high-side turn-on escapes afterwards. A second overlap is a dead-time load requested while a phase is busy. The bench judges this by measuring the next gap, which must still show the old dead time.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_PULSE,
    PH_DEAD,
    PH_HI,
    PH_LO
  } ph_state_t;

  // Effective dead time: the requested count, raised to the floor when lower.
  function automatic int unsigned dt_effective(input int unsigned req,
                                               input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

endpackage

// File: rtl/gtc_dt_config.sv
module gtc_dt_config #(
  parameter int DT_W       = 12,
  parameter int DT_DEFAULT = 1500,
  parameter int DT_MIN     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DT_W-1:0] req,
  input  logic            all_idle,
  output logic [DT_W-1:0] dt_q
);

  logic load_ok;
  assign load_ok = load & all_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dt_q <= DT_W'(DT_DEFAULT);
    else if (load_ok) dt_q <= DT_W'(gtc_pkg::dt_effective(32'(req), DT_MIN));
  end

  // R7: a busy block keeps its dead time
  p_busy_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !all_idle) |=> $stable(dt_q));

  // R7: dead time never below the floor
  p_dt_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dt_q >= DT_W'(DT_MIN));

endmodule

// File: rtl/gtc_phase.sv
module gtc_phase #(
  parameter int DT_W         = 12,
  parameter int PULSE_CYCLES = 450
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill,
  input  logic            en,
  input  logic            pwm,
  input  logic [DT_W-1:0] dt,
  output logic            gate_hi,
  output logic            gate_lo,
  output logic            sw_strobe,
  output logic            idle
);
  import gtc_pkg::*;

  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam int CNT_W   = (DT_W > PULSE_W) ? DT_W : PULSE_W;

  ph_state_t        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             hi_n, lo_n;
  logic             armed, armed_n;
  logic             en_edge;
  logic             cnt_done;
  logic [CNT_W-1:0] dt_load_val;

  assign en_edge     = en & ~armed;
  assign cnt_done    = (cnt == '0);
  assign dt_load_val = CNT_W'(dt) - CNT_W'(1);
  assign armed_n     = en & ~kill;
  assign idle        = (st == PH_OFF);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    hi_n  = gate_hi;
    lo_n  = gate_lo;
    if (kill || !en) begin
      st_n  = PH_OFF;
      cnt_n = '0;
      hi_n  = 1'b0;
      lo_n  = 1'b0;
    end else if (en_edge) begin
      st_n  = PH_PULSE;
      cnt_n = CNT_W'(PULSE_CYCLES - 1);
      hi_n  = 1'b0;
      lo_n  = 1'b1;
    end else begin
      unique case (st)
        PH_PULSE: begin
          if (!cnt_done) cnt_n = cnt - CNT_W'(1);
          else if (pwm) begin
            lo_n  = 1'b0;
            st_n  = PH_DEAD;
            cnt_n = dt_load_val;
          end else st_n = PH_LO;
        end
        PH_LO: begin
          if (pwm) begin
            lo_n  = 1'b0;
            st_n  = PH_DEAD;
            cnt_n = dt_load_val;
          end
        end
        PH_HI: begin
          if (!pwm) begin
            hi_n  = 1'b0;
            st_n  = PH_DEAD;
            cnt_n = dt_load_val;
          end
        end
        PH_DEAD: begin
          if (!cnt_done) cnt_n = cnt - CNT_W'(1);
          else if (pwm) begin
            hi_n = 1'b1;
            st_n = PH_HI;
          end else begin
            lo_n = 1'b1;
            st_n = PH_LO;
          end
        end
        default: st_n = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_OFF;
      cnt       <= '0;
      gate_hi   <= 1'b0;
      gate_lo   <= 1'b0;
      armed     <= 1'b0;
      sw_strobe <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      gate_hi   <= hi_n;
      gate_lo   <= lo_n;
      armed     <= armed_n;
      sw_strobe <= (hi_n & ~gate_hi) | (lo_n & ~gate_lo);
    end
  end

  // R8
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R9
  p_kill_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!gate_hi && !gate_lo));

  // R2
  p_disabled_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_hi && !gate_lo));

  // R4
  p_enable_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !armed && !kill) |=> (gate_lo && !gate_hi));

  // R10
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe == ($rose(gate_hi) || $rose(gate_lo)));

  // R6: high side only turns on out of a gap
  p_hi_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(!gate_lo && !gate_hi));

endmodule

// File: rtl/gate_timing_ctrl.sv
module gate_timing_ctrl #(
  parameter int NUM_PH       = 3,
  parameter int DT_W         = 12,
  parameter int DT_DEFAULT   = 1500,
  parameter int DT_MIN       = 8,
  parameter int PULSE_CYCLES = 450
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              all_off,
  input  logic [NUM_PH-1:0] phase_en,
  input  logic [NUM_PH-1:0] pwm_in,
  input  logic              dt_load,
  input  logic [DT_W-1:0]   dt_cycles,
  output logic [NUM_PH-1:0] gate_hi,
  output logic [NUM_PH-1:0] gate_lo,
  output logic [NUM_PH-1:0] sw_strobe
);

  logic [NUM_PH-1:0] idle_vec;
  logic              all_idle;
  logic [DT_W-1:0]   dt_q;

  assign all_idle = &idle_vec;

  gtc_dt_config #(
    .DT_W(DT_W), .DT_DEFAULT(DT_DEFAULT), .DT_MIN(DT_MIN)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .load(dt_load), .req(dt_cycles),
    .all_idle(all_idle), .dt_q(dt_q)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    gtc_phase #(
      .DT_W(DT_W), .PULSE_CYCLES(PULSE_CYCLES)
    ) i_ph (
      .clk(clk), .rst_n(rst_n), .kill(all_off), .en(phase_en[p]),
      .pwm(pwm_in[p]), .dt(dt_q), .gate_hi(gate_hi[p]),
      .gate_lo(gate_lo[p]), .sw_strobe(sw_strobe[p]), .idle(idle_vec[p])
    );
  end

  // R9: global off reaches every phase
  p_all_off_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/test_gate_timing_ctrl.sv
`timescale 1ns/1ps
module test_gate_timing_ctrl;
  localparam int NPH = 3;
  localparam int DW  = 8;
  localparam int PC  = 6;
  localparam int DTD = 10;
  localparam int DTM = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic all_off;
  logic [NPH-1:0] phase_en, pwm_in, gate_hi, gate_lo, sw_strobe;
  logic dt_load;
  logic [DW-1:0] dt_cycles;

  int checks = 0, failures = 0, overlaps = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gate_timing_ctrl #(.NUM_PH(NPH), .DT_W(DW), .DT_DEFAULT(DTD),
                     .DT_MIN(DTM), .PULSE_CYCLES(PC)) i_gate_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .all_off(all_off), .phase_en(phase_en),
    .pwm_in(pwm_in), .dt_load(dt_load), .dt_cycles(dt_cycles),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .sw_strobe(sw_strobe));

  always @(negedge clk) if (rst_n && ((gate_hi & gate_lo) != '0)) overlaps++;

  // {en, pwm, expected hi, expected lo}, settled values
  localparam logic [11:0] VEC [8] = '{
    {3'b000, 3'b111, 3'b000, 3'b000},
    {3'b111, 3'b000, 3'b000, 3'b111},
    {3'b111, 3'b101, 3'b101, 3'b010},
    {3'b111, 3'b010, 3'b010, 3'b101},
    {3'b011, 3'b110, 3'b010, 3'b001},
    {3'b100, 3'b011, 3'b000, 3'b100},
    {3'b101, 3'b111, 3'b101, 3'b000},
    {3'b000, 3'b000, 3'b000, 3'b000}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int ph, output int lo_n, output int gap,
                         output int strb);
    lo_n = 0; gap = 0; strb = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sw_strobe[ph]) strb++;
      if (gate_hi[ph]) break;
      else if (gate_lo[ph] && gap > 0) break;
      else if (gate_lo[ph]) lo_n++;
      else gap++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo_n, gap, strb;
    rst_n = 1'b0; all_off = 1'b0; phase_en = '0; pwm_in = '0;
    dt_load = 1'b0; dt_cycles = '0;
    cycles(3);
    check("R1 reset gate_hi", int'(gate_hi), 0);
    check("R1 reset gate_lo", int'(gate_lo), 0);
    check("R1 reset sw_strobe", int'(sw_strobe), 0);
    rst_n = 1'b1;
    cycles(2);

    for (int v = 0; v < 8; v++) begin
      phase_en = VEC[v][11:9];
      pwm_in   = VEC[v][8:6];
      cycles(40);
      check($sformatf("R2/R3 vector %0d gate_hi", v), int'(gate_hi), int'(VEC[v][5:3]));
      check($sformatf("R2/R3 vector %0d gate_lo", v), int'(gate_lo), int'(VEC[v][2:0]));
    end

    // R2: PWM toggling on a disabled phase
    for (int i = 0; i < 10; i++) begin pwm_in = 3'(i); @(negedge clk);
      if (gate_hi != '0 || gate_lo != '0) check("R2 disabled toggling", 1, 0);
    end
    check("R2 disabled gates after toggling", int'(gate_hi | gate_lo), 0);

    // R4/R5 with default dead time (R1)
    pwm_in = 3'b001; phase_en = 3'b001;
    measure(0, lo_n, gap, strb);
    check("R4 pulse length", lo_n, PC);
    check("R5 gap after pulse (R1 default dt)", gap, DTD);
    check("R3 high side on", int'(gate_hi[0]), 1);
    check("R10 strobes pulse+hi", strb, 2);

    // R6 both directions
    pwm_in = 3'b000;
    measure(0, lo_n, gap, strb);
    check("R6 gap hi->lo", gap, DTD);
    check("R6 low on", int'(gate_lo[0]), 1);
    pwm_in = 3'b001;
    measure(0, lo_n, gap, strb);
    check("R6 gap lo->hi", gap, DTD);
    check("R10 single strobe", strb, 1);

    // R5 low PWM at pulse end: low stays on
    phase_en = 3'b000; cycles(3);
    pwm_in = 3'b000; phase_en = 3'b001;
    cycles(PC + 4);
    check("R5 low continues after pulse", int'(gate_lo[0]), 1);

    // R7 load while idle
    phase_en = 3'b000; cycles(3);
    dt_load = 1'b1; dt_cycles = 8'd5; @(negedge clk); dt_load = 1'b0;
    pwm_in = 3'b001; phase_en = 3'b001;
    measure(0, lo_n, gap, strb);
    check("R7 loaded dt", gap, 5);
    dt_load = 1'b1; dt_cycles = 8'd7; @(negedge clk); dt_load = 1'b0;
    pwm_in = 3'b000;
    measure(0, lo_n, gap, strb);
    check("R7 busy load ignored", gap, 5);
    phase_en = 3'b000; cycles(3);
    dt_load = 1'b1; dt_cycles = 8'd0; @(negedge clk); dt_load = 1'b0;
    pwm_in = 3'b001; phase_en = 3'b001;
    measure(0, lo_n, gap, strb);
    check("R7 floor clamp", gap, DTM);

    // R9 kill mid pulse, restart on release
    phase_en = 3'b000; cycles(3);
    pwm_in = 3'b010; phase_en = 3'b010; cycles(3);
    all_off = 1'b1; @(negedge clk);
    check("R9 kill clears hi", int'(gate_hi), 0);
    check("R9 kill clears lo", int'(gate_lo), 0);
    all_off = 1'b0; @(negedge clk);
    check("R9 restart pulse", int'(gate_lo), 2);
    // R9 kill inside a dead gap
    cycles(PC + 1);
    all_off = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge clk);
      if (gate_hi != '0 || gate_lo != '0) check("R9 held off", 1, 0);
    end
    check("R9 nothing escapes kill", int'(gate_hi | gate_lo), 0);
    all_off = 1'b0; phase_en = 3'b000; cycles(3);

    // R8 fast PWM toggling
    phase_en = 3'b111;
    for (int i = 0; i < 200; i++) begin pwm_in = 3'((i * 5) >> 2); @(negedge clk); end
    check("R8 no overlap seen", overlaps, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule